// File: doc/BRIEF.md
# Graphics memory region address translator

This block sits beside a 2D drawing engine and turns the 24-bit offsets of its memory transfers into 32-bit physical addresses. Three data channels (destination, source and a third data stream) each own a 10-bit region base that counts in 4 MB steps. The two top bits of a channel's offset are added to its base to choose a 4 MB slice. The lower 22 offset bits pass through unchanged. Each channel therefore sees a private 16 MB window, and offsets wrap inside that window.

A small register port holds the three bases in one word, a command-buffer start field, and a sticky flag. Together with an external 8-bit command base, the start field forms the 32-bit address at which command fetching begins. The start field may only change while the command engine is idle. A write that arrives while the engine is busy is dropped and recorded in the flag. Translated addresses are registered and follow the offset by one clock.

Top module: `gfx_region_xlat`

## Requirements
- R1: After reset, select 0 reads 0x01004010 (all three bases equal 4), select 1 reads 0 and select 2 reads 0.
- R2: Select 0 holds the destination base in bits 31:22, the source base in bits 21:12 and the third-channel base in bits 11:2. Written bits 1:0 are discarded and read as zero.
- R3: For each channel, address bits 31:22 equal the channel base plus offset bits 23:22, and address bits 21:0 equal offset bits 21:0.
- R4: When the base plus offset bits 23:22 exceeds 1023, the upper address field wraps modulo 1024 rather than saturating.
- R5: Each channel translates with its own base, so the three channels can reach different regions in the same cycle.
- R6: out_valid is in_valid delayed by one clock. The addresses take the values for the offsets presented with in_valid on the next clock and hold while in_valid is low.
- R7: Select 1 stores written bits 23:5. Bits 31:24 and 4:0 always read as zero.
- R8: cmd_start_addr equals cmd_base in bits 31:24, the stored select-1 field in bits 23:5, and zero in bits 4:0.
- R9: A select-1 write takes effect when eng_busy is low, or when cmd_rd_ptr equals cmd_wr_ptr.
- R10: A select-1 write made while eng_busy is high and the pointers differ leaves the field unchanged and sets bit 0 of select 2.
- R11: A read strobe (reg_re) at select 2 clears the flag after that cycle. A rejected write in the same cycle keeps the flag set.
- R12: Writes to selects 2 and 3 change nothing, and select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 bases, 1 command start, 2 flag, 3 none |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Read strobe, used to clear the flag on read |
| reg_rdata | output | 32 | Register read data for reg_sel |
| eng_busy | input | 1 | Command engine busy |
| cmd_rd_ptr | input | 16 | Command read pointer |
| cmd_wr_ptr | input | 16 | Command write pointer |
| cmd_base | input | 8 | Upper byte of the command-buffer address |
| cmd_start_addr | output | 32 | Command-buffer start address |
| in_valid | input | 1 | Offsets valid |
| dst_off | input | 24 | Destination offset |
| src_off | input | 24 | Source offset |
| ch3_off | input | 24 | Third-channel offset |
| out_valid | output | 1 | Addresses valid |
| dst_addr | output | 32 | Destination physical address |
| src_addr | output | 32 | Source physical address |
| ch3_addr | output | 32 | Third-channel physical address |

## Verification
The bench pushes a base of 1023 against offsets whose top bits are 3. A design that saturated, or that let the carry leak into the pass-through bits, would produce a wrong upper field. It gives the three channels distinct bases under identical offsets, which exposes a design that shares one base or swaps the field positions. It writes the command start while the engine is busy, both with equal pointers (the write must land) and with differing pointers (the field must stay unchanged and the flag must rise). It then reads the flag twice to confirm that it clears on read. A long random phase follows, comparing every output on every clock against a behavioural model. That phase catches a design that is off by one cycle, fails to hold its addresses, or leaks reserved bits.

// File: rtl/gxl_pkg.sv
package gxl_pkg;
  localparam int unsigned BASE_W  = 10;
  localparam int unsigned OFF_W   = 24;
  localparam int unsigned PASS_W  = OFF_W - 2;
  localparam int unsigned ADDR_W  = BASE_W + PASS_W;
  localparam int unsigned CMDB_W  = ADDR_W - OFF_W;
  localparam int unsigned CMD_LSB = 5;
  localparam int unsigned CMD_W   = OFF_W - CMD_LSB;
  localparam int unsigned NCH     = 3;
  localparam int unsigned PTR_W   = 16;

  localparam logic [BASE_W-1:0] BASE_RST = BASE_W'(4);

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gxl_rst_sync.sv
module gxl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/gxl_chan_xlat.sv
module gxl_chan_xlat #(
  parameter int unsigned BASE_W = gxl_pkg::BASE_W,
  parameter int unsigned OFF_W  = gxl_pkg::OFF_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [BASE_W-1:0]         base,
  input  logic [OFF_W-1:0]          off,
  output logic [BASE_W+OFF_W-3:0]   addr
);
  localparam int unsigned PASS_W = OFF_W - 2;
  localparam int unsigned ADDR_W = BASE_W + PASS_W;

  logic [BASE_W-1:0] hi_d;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    hi_d   = base + BASE_W'(off[OFF_W-1 -: 2]);
    addr_d = {hi_d, off[PASS_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_q <= '0;
    else if (in_valid) addr_q <= addr_d;
  end

  assign addr = addr_q;

  p_pass_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> addr[PASS_W-1:0] == $past(off[PASS_W-1:0]));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(addr));
endmodule

// File: rtl/gxl_regs.sv
module gxl_regs
  import gxl_pkg::*;
#(
  parameter int unsigned RW   = ADDR_W,
  parameter int unsigned BW   = BASE_W,
  parameter int unsigned NC   = NCH,
  parameter int unsigned PW   = PTR_W,
  parameter int unsigned CBW  = CMDB_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           reg_sel,
  input  logic [RW-1:0]        reg_wdata,
  input  logic                 reg_we,
  input  logic                 reg_re,
  output logic [RW-1:0]        reg_rdata,
  input  logic                 eng_busy,
  input  logic [PW-1:0]        cmd_rd_ptr,
  input  logic [PW-1:0]        cmd_wr_ptr,
  input  logic [CBW-1:0]       cmd_base,
  output logic [RW-1:0]        cmd_start_addr,
  output logic [NC-1:0][BW-1:0] base_o
);
  localparam int unsigned TOP_LSB = CMD_LSB;
  localparam int unsigned TOP_W   = RW - CBW - TOP_LSB;

  reg_sel_e              sel;
  logic [NC-1:0][BW-1:0] base_q, base_d;
  logic [TOP_W-1:0]      top_q, top_d;
  logic                  rej_q, rej_d;
  logic                  cmd_idle, wr_base, wr_cmd, wr_reject, rd_stat;

  // next state
  always_comb begin
    sel       = reg_sel_e'(reg_sel);
    cmd_idle  = !eng_busy || (cmd_rd_ptr == cmd_wr_ptr);
    wr_base   = reg_we && (sel == SEL_BASE);
    wr_cmd    = reg_we && (sel == SEL_CMD) && cmd_idle;
    wr_reject = reg_we && (sel == SEL_CMD) && !cmd_idle;
    rd_stat   = reg_re && (sel == SEL_STAT);
    for (int i = 0; i < NC; i++) begin
      base_d[i] = reg_wdata[RW-1-i*BW -: BW];
    end
    top_d = reg_wdata[TOP_LSB+TOP_W-1:TOP_LSB];
    if (wr_reject)    rej_d = 1'b1;
    else if (rd_stat) rej_d = 1'b0;
    else              rej_d = rej_q;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= {NC{BASE_RST}};
      top_q  <= '0;
      rej_q  <= 1'b0;
    end else begin
      if (wr_base) base_q <= base_d;
      if (wr_cmd)  top_q  <= top_d;
      rej_q <= rej_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_BASE: begin
        for (int i = 0; i < NC; i++) begin
          reg_rdata[RW-1-i*BW -: BW] = base_q[i];
        end
      end
      SEL_CMD:  reg_rdata[TOP_LSB+TOP_W-1:TOP_LSB] = top_q;
      SEL_STAT: reg_rdata[0] = rej_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign cmd_start_addr = {cmd_base, top_q, {TOP_LSB{1'b0}}};
  assign base_o         = base_q;

  p_reject_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable(cmd_start_addr[RW-CBW-1:0]));

  p_reject_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> rej_q);

  p_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !wr_reject) |=> !rej_q);

  p_cmd_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CMD) |-> (reg_rdata[RW-1:RW-CBW] == '0 && reg_rdata[TOP_LSB-1:0] == '0));

  p_idle_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel == SEL_CMD && cmd_idle) |=>
      cmd_start_addr[RW-CBW-1:TOP_LSB] == $past(reg_wdata[RW-CBW-1:TOP_LSB]));
endmodule

// File: rtl/gfx_region_xlat.sv
module gfx_region_xlat
  import gxl_pkg::*;
#(
  parameter int unsigned PTR_BITS = PTR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          reg_sel,
  input  logic [ADDR_W-1:0]   reg_wdata,
  input  logic                reg_we,
  input  logic                reg_re,
  output logic [ADDR_W-1:0]   reg_rdata,
  input  logic                eng_busy,
  input  logic [PTR_BITS-1:0] cmd_rd_ptr,
  input  logic [PTR_BITS-1:0] cmd_wr_ptr,
  input  logic [CMDB_W-1:0]   cmd_base,
  output logic [ADDR_W-1:0]   cmd_start_addr,
  input  logic                in_valid,
  input  logic [OFF_W-1:0]    dst_off,
  input  logic [OFF_W-1:0]    src_off,
  input  logic [OFF_W-1:0]    ch3_off,
  output logic                out_valid,
  output logic [ADDR_W-1:0]   dst_addr,
  output logic [ADDR_W-1:0]   src_addr,
  output logic [ADDR_W-1:0]   ch3_addr
);
  logic                       rst_int_n;
  logic [NCH-1:0][BASE_W-1:0] base_w;
  logic [NCH-1:0][OFF_W-1:0]  off_w;
  logic [NCH-1:0][ADDR_W-1:0] addr_w;
  logic                       vld_q;

  gxl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  gxl_regs #(.PW(PTR_BITS)) u_regs (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .reg_sel        (reg_sel),
    .reg_wdata      (reg_wdata),
    .reg_we         (reg_we),
    .reg_re         (reg_re),
    .reg_rdata      (reg_rdata),
    .eng_busy       (eng_busy),
    .cmd_rd_ptr     (cmd_rd_ptr),
    .cmd_wr_ptr     (cmd_wr_ptr),
    .cmd_base       (cmd_base),
    .cmd_start_addr (cmd_start_addr),
    .base_o         (base_w)
  );

  assign off_w = {ch3_off, src_off, dst_off};

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    gxl_chan_xlat #(.BASE_W(BASE_W), .OFF_W(OFF_W)) u_xlat (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .in_valid (in_valid),
      .base     (base_w[g]),
      .off      (off_w[g]),
      .addr     (addr_w[g])
    );
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) vld_q <= 1'b0;
    else            vld_q <= in_valid;
  end

  assign out_valid = vld_q;
  assign dst_addr  = addr_w[0];
  assign src_addr  = addr_w[1];
  assign ch3_addr  = addr_w[2];

  p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);

  p_valid_fall_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid);

  p_cmd_hi_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_start_addr[ADDR_W-1 -: CMDB_W] == cmd_base && cmd_start_addr[CMD_LSB-1:0] == '0);
endmodule

// File: tb/tb_gfx_region_xlat.sv
`timescale 1ns/1ps
module tb_gfx_region_xlat;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        reg_we, reg_re;
  logic [31:0] reg_rdata;
  logic        eng_busy;
  logic [15:0] cmd_rd_ptr, cmd_wr_ptr;
  logic [7:0]  cmd_base;
  logic [31:0] cmd_start_addr;
  logic        in_valid;
  logic [23:0] dst_off, src_off, ch3_off;
  logic        out_valid;
  logic [31:0] dst_addr, src_addr, ch3_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  int m_b[3];
  int m_top;
  bit m_flag;
  bit m_ov;
  longint m_a[3];

  always #4 clk = ~clk;

  gfx_region_xlat dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .eng_busy(eng_busy), .cmd_rd_ptr(cmd_rd_ptr), .cmd_wr_ptr(cmd_wr_ptr),
    .cmd_base(cmd_base), .cmd_start_addr(cmd_start_addr),
    .in_valid(in_valid), .dst_off(dst_off), .src_off(src_off), .ch3_off(ch3_off),
    .out_valid(out_valid), .dst_addr(dst_addr), .src_addr(src_addr), .ch3_addr(ch3_addr)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint xl(int b, int off);
    return ((b + (off / 4194304)) % 1024) * 64'd4194304 + (off % 4194304);
  endfunction

  function automatic longint exp_rd(int s);
    case (s)
      0: return m_b[0] * 64'd4194304 + m_b[1] * 64'd4096 + m_b[2] * 64'd4;
      1: return m_top * 64'd32;
      2: return longint'(m_flag);
      default: return 0;
    endcase
  endfunction

  // model update at each edge, compare shortly after
  always @(posedge clk) begin
    bit rej;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_b[i] = 4; m_a[i] = 0; end
      m_top = 0; m_flag = 0; m_ov = 0;
    end else begin
      if (in_valid) begin
        m_a[0] = xl(m_b[0], int'(dst_off));
        m_a[1] = xl(m_b[1], int'(src_off));
        m_a[2] = xl(m_b[2], int'(ch3_off));
      end
      m_ov = in_valid;
      rej = reg_we && reg_sel == 2'd1 && eng_busy && (cmd_rd_ptr != cmd_wr_ptr);
      if (reg_we && reg_sel == 2'd0) begin
        m_b[0] = int'(reg_wdata >> 22) % 1024;
        m_b[1] = int'(reg_wdata >> 12) % 1024;
        m_b[2] = int'(reg_wdata >> 2) % 1024;
      end
      if (reg_we && reg_sel == 2'd1 && !rej) m_top = int'(reg_wdata >> 5) % 524288;
      if (rej) m_flag = 1;
      else if (reg_re && reg_sel == 2'd2) m_flag = 0;
    end
    #1;
    if (rst_n && !done) begin
      case (reg_sel)
        2'd0: chk("R2 base readback", reg_rdata, exp_rd(0));
        2'd1: chk("R7 cmd readback", reg_rdata, exp_rd(1));
        2'd2: chk("R10 flag readback", reg_rdata, exp_rd(2));
        default: chk("R12 empty select", reg_rdata, 0);
      endcase
      chk("R8 cmd start addr", cmd_start_addr, longint'(cmd_base) * 64'd16777216 + m_top * 64'd32);
      chk("R6 out_valid", out_valid, m_ov);
      chk("R3 dst addr", dst_addr, m_a[0]);
      chk("R3 src addr", src_addr, m_a[1]);
      chk("R3 ch3 addr", ch3_addr, m_a[2]);
    end
  end

  task automatic wr(logic [1:0] s, logic [31:0] d);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_sel = 2'd0; reg_wdata = '0; reg_we = 1'b0; reg_re = 1'b0;
    eng_busy = 1'b0; cmd_rd_ptr = '0; cmd_wr_ptr = '0; cmd_base = 8'h00;
    in_valid = 1'b0; dst_off = '0; src_off = '0; ch3_off = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    reg_sel = 2'd0; #1 chk("R1 reset base", reg_rdata, 32'h01004010);
    reg_sel = 2'd1; #1 chk("R1 reset cmd", reg_rdata, 0);
    reg_sel = 2'd2; #1 chk("R1 reset flag", reg_rdata, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 layout, reserved low bits dropped
    wr(2'd0, {10'h3FF, 10'h001, 10'h155, 2'b11});
    reg_sel = 2'd0; #1 chk("R2 fields", reg_rdata, {10'h3FF, 10'h001, 10'h155, 2'b00});
    @(negedge clk);

    // R4 wrap, R5 independent bases
    dst_off = 24'hC12345; src_off = 24'h400000; ch3_off = 24'h000ABC; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 wrap dst", dst_addr, 32'h00812345);
    chk("R5 src base", src_addr, 32'h00800000);
    chk("R5 ch3 base", ch3_addr, 32'h55400ABC);
    chk("R6 valid lag", out_valid, 1);
    @(negedge clk);
    chk("R6 valid drop", out_valid, 0);
    chk("R6 hold", dst_addr, 32'h00812345);

    // R9 busy but pointers equal: accepted
    eng_busy = 1'b1; cmd_rd_ptr = 16'd5; cmd_wr_ptr = 16'd5; cmd_base = 8'hA5;
    wr(2'd1, 32'hFFFFFFFF);
    reg_sel = 2'd1; #1 chk("R9 write accepted", reg_rdata, 32'h00FFFFE0);
    chk("R8 start addr", cmd_start_addr, 32'hA5FFFFE0);
    @(negedge clk);

    // R10 busy and pointers differ: rejected
    cmd_wr_ptr = 16'd6;
    wr(2'd1, 32'h00123440);
    reg_sel = 2'd1; #1 chk("R10 write ignored", reg_rdata, 32'h00FFFFE0);
    @(negedge clk);
    reg_sel = 2'd2; #1 chk("R10 flag set", reg_rdata, 1);
    @(negedge clk);
    // R11 clear on read
    reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    chk("R11 flag cleared", reg_rdata, 0);

    // R12 writes to selects 2 and 3 have no effect
    wr(2'd2, 32'hFFFFFFFF);
    wr(2'd3, 32'hFFFFFFFF);
    reg_sel = 2'd3; #1 chk("R12 sel3 zero", reg_rdata, 0);
    reg_sel = 2'd2; #1 chk("R12 flag untouched", reg_rdata, 0);
    reg_sel = 2'd0; #1 chk("R12 base untouched", reg_rdata, {10'h3FF, 10'h001, 10'h155, 2'b00});
    eng_busy = 1'b0;
    @(negedge clk);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      reg_sel    = 2'($urandom_range(0, 3));
      reg_wdata  = $urandom;
      reg_we     = ($urandom_range(0, 3) == 0);
      reg_re     = ($urandom_range(0, 2) == 0);
      eng_busy   = $urandom_range(0, 1) == 1;
      cmd_rd_ptr = 16'($urandom_range(0, 2));
      cmd_wr_ptr = 16'($urandom_range(0, 2));
      cmd_base   = 8'($urandom);
      in_valid   = $urandom_range(0, 1) == 1;
      dst_off    = 24'($urandom);
      src_off    = 24'($urandom);
      ch3_off    = 24'($urandom);
      @(negedge clk);
    end
    reg_we = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule